// File: doc/BRIEF.md
# Four-Channel Time-over-Threshold Timestamper

This block timestamps pulses from four digital discriminator inputs. Each input comes from an external threshold comparator and is asynchronous to the clock. A free-running counter supplies one time base that all channels share. Each input passes through a synchronizer chain. Both level changes of the synchronized signal are then detected. On each change, the block records the counter value, the channel number and the direction of the change.

Each channel puts its records into its own small queue. A round-robin arbiter merges the four queues into one valid/ready word stream for the host link. The host subtracts the rising-edge time from the falling-edge time of the same channel to get the time over threshold. That width grows roughly with the logarithm of the pulse amplitude, so any width up to one counter wrap is usable. When a queue is full, a new record for that channel is discarded and a sticky overflow flag is raised. The host clears the flag with a one-cycle clear pulse.

Top module: `tot_stamper`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ev_valid` is 0 and `ovf_flag` is 0.
- R2: The time counter is 0 after reset and advances by one each clock. A level change that is present at an input before clock edge k (edges counted from 1 after reset release) is stamped with the value k+1. This is a fixed offset of SYNC-1 cycles, the same on every channel and for both edge directions.
- R3: Both a low-to-high and a high-to-low change produce a record. The polarity bit is 1 for low-to-high and 0 for high-to-low.
- R4: Record layout: bits [REC_W-1 -: CH_W] hold the channel number, the next bit down holds the polarity, and bits [TS_W-1:0] hold the timestamp.
- R5: Each channel holds up to DEPTH records and delivers them in arrival order. A record that arrives while its channel queue is full is discarded.
- R6: Arbitration is round-robin. After channel c is served, the search for the next record starts at channel c+1. After reset the search starts at channel 0.
- R7: While `ev_valid` is 1 and `ev_ready` is 0, `ev_valid` stays 1 and `ev_data` keeps its value, even when new records arrive.
- R8: `ovf_flag` is set when a record is discarded and stays set until a cycle with `ovf_clr` high and no new discard, after which it reads 0.
- R9: The timestamp wraps modulo 2^TS_W, so the width of a pulse that crosses the wrap is the difference of its two stamps modulo 2^TS_W.
- R10: For a pulse of W cycles on one channel, the falling-edge timestamp minus the rising-edge timestamp equals W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disc_in | input | NCH | Asynchronous discriminator levels, one per channel |
| ovf_clr | input | 1 | One-cycle pulse that clears the overflow flag |
| ev_valid | output | 1 | A record is offered on `ev_data` |
| ev_ready | input | 1 | The host accepts the offered record this cycle |
| ev_data | output | CH_W+1+TS_W | Record: channel, polarity, timestamp |
| ovf_flag | output | 1 | Sticky indicator that a record was discarded |

## Verification
The embedded properties check on every cycle that no queue fill exceeds DEPTH and that the granted channel always has a pending record. They also check that an offered record holds still under back-pressure, and that the overflow flag stays set until a clear pulse and drops after one. Only the directed scenarios can show the exact timestamp offset through the synchronizer, the rising/falling pairing and measured width of a pulse, and the round-robin delivery order of simultaneous edges. The same applies to the arrival order and discard point of a full queue, and to the modular width of a pulse that straddles the counter wrap.

// File: rtl/tot_stamper.sv
module tot_stamper #(
  parameter int NCH   = 4,
  parameter int TS_W  = 30,
  parameter int DEPTH = 4,
  parameter int SYNC  = 2,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int REC_W = CH_W + 1 + TS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   disc_in,
  input  logic             ovf_clr,
  output logic             ev_valid,
  input  logic             ev_ready,
  output logic [REC_W-1:0] ev_data,
  output logic             ovf_flag
);
  localparam int ENT_W = TS_W + 1;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;

  logic [TS_W-1:0]  ts_cnt;
  logic [NCH-1:0]   lvl_q, hit, rise, push, drop, pop, full, nonempty;
  logic [ENT_W-1:0] head [NCH];
  logic [CH_W-1:0]  rr_last, pick, lock_ch, gnt;
  logic             lock;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ts_cnt <= '0;
    else        ts_cnt <= ts_cnt + 1'b1;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SYNC-1:0]  sync_q;
    logic [ENT_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [CNT_W-1:0] fill;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        sync_q   <= '0;
        lvl_q[c] <= 1'b0;
      end else begin
        sync_q   <= {sync_q[SYNC-2:0], disc_in[c]};
        lvl_q[c] <= sync_q[SYNC-1];
      end

    assign hit[c]      = sync_q[SYNC-1] ^ lvl_q[c];
    assign rise[c]     = sync_q[SYNC-1];
    assign full[c]     = (fill == CNT_W'(DEPTH));
    assign nonempty[c] = (fill != '0);
    assign push[c]     = hit[c] & ~full[c];
    assign drop[c]     = hit[c] & full[c];
    assign pop[c]      = ev_valid & ev_ready & (gnt == CH_W'(c));
    assign head[c]     = mem[rp];

    always_ff @(posedge clk)
      if (push[c]) mem[wp] <= {rise[c], ts_cnt};

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        wp   <= '0;
        rp   <= '0;
        fill <= '0;
      end else begin
        if (push[c]) wp <= wp + 1'b1;
        if (pop[c])  rp <= rp + 1'b1;
        if (push[c] && !pop[c])      fill <= fill + 1'b1;
        else if (!push[c] && pop[c]) fill <= fill - 1'b1;
      end

    p_no_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CNT_W'(DEPTH));
  end

  always_comb begin
    logic found;
    found = 1'b0;
    pick  = rr_last;
    for (int i = 1; i <= NCH; i++) begin
      if (!found && nonempty[CH_W'((int'(rr_last) + i) % NCH)]) begin
        pick  = CH_W'((int'(rr_last) + i) % NCH);
        found = 1'b1;
      end
    end
  end

  assign gnt      = lock ? lock_ch : pick;
  assign ev_valid = |nonempty;
  assign ev_data  = {gnt, head[gnt]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rr_last <= CH_W'(NCH - 1);
      lock    <= 1'b0;
      lock_ch <= '0;
    end else if (ev_valid && ev_ready) begin
      rr_last <= gnt;
      lock    <= 1'b0;
    end else if (ev_valid) begin
      lock    <= 1'b1;
      lock_ch <= gnt;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     ovf_flag <= 1'b0;
    else if (|drop) ovf_flag <= 1'b1;
    else if (ovf_clr) ovf_flag <= 1'b0;

  p_grant_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> nonempty[gnt]);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready |=> ev_valid && $stable(ev_data));
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !ovf_clr |=> ovf_flag);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clr && !(|drop) |=> !ovf_flag);
endmodule

// File: tb/tot_stamper_bench.sv
`timescale 1ns/100ps
module tot_stamper_bench;
  localparam int NCH = 4, TSW = 12, DEPTH = 4, SYNC = 2;
  localparam int RW = 2 + 1 + TSW;

  logic clk = 0, rst_n = 0, ovf_clr = 0, ev_ready = 0, ev_valid, ovf_flag;
  logic [NCH-1:0] disc_in = '0;
  logic [RW-1:0] ev_data;
  int tick = 0, checks = 0, fails = 0, ngot = 0;
  logic [RW-1:0] got [16];

  always #2.5 clk = ~clk;

  tot_stamper #(.NCH(NCH), .TS_W(TSW), .DEPTH(DEPTH), .SYNC(SYNC)) u_tot_stamper (
    .clk(clk), .rst_n(rst_n), .disc_in(disc_in), .ovf_clr(ovf_clr),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_data(ev_data), .ovf_flag(ovf_flag));

  always @(posedge clk) tick <= rst_n ? tick + 1 : 0;

  always @(negedge clk) begin
    #1;
    if (rst_n && ev_valid && ev_ready && ngot < 16) begin
      got[ngot] = ev_data;
      ngot++;
    end
  end

  function automatic logic [RW-1:0] mk(int ch, bit pol, int ts);
    return {2'(ch), pol, TSW'(ts)};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; disc_in = '0; ev_ready = 0; ovf_clr = 0;
    step(3);
    rst_n = 1;
    ngot = 0;
  endtask

  task automatic wait_got(int n);
    for (int i = 0; i < 300 && ngot < n; i++) step(1);
  endtask

  task automatic t_reset();
    @(negedge clk); rst_n = 0; #1;
    chk("R1 valid in reset", ev_valid, 0);
    chk("R1 ovf in reset", ovf_flag, 0);
    step(2); rst_n = 1; @(negedge clk); #1;
    chk("R1 valid after reset", ev_valid, 0);
    chk("R1 ovf after reset", ovf_flag, 0);
  endtask

  task automatic t_single_pulse();
    int c1, c2;
    do_reset(); ev_ready = 1; step(5);
    c1 = tick; disc_in[2] = 1;
    step(37);
    c2 = tick; disc_in[2] = 0;
    wait_got(2); step(5);
    chk("R5 pulse record count", ngot, 2);
    chk("R2 R3 R4 rising record", got[0], mk(2, 1, c1 + 2));
    chk("R2 R3 R4 falling record", got[1], mk(2, 0, c2 + 2));
    chk("R10 pulse width", TSW'(got[1][TSW-1:0] - got[0][TSW-1:0]), 37);
  endtask

  task automatic t_round_robin();
    int c;
    do_reset(); step(4);
    c = tick; disc_in = 4'b0011;
    step(3); disc_in[0] = 0;
    step(8); ev_ready = 1;
    wait_got(3); step(4);
    chk("R6 rr count", ngot, 3);
    chk("R6 rr first ch0", got[0], mk(0, 1, c + 2));
    chk("R6 rr second ch1", got[1], mk(1, 1, c + 2));
    chk("R6 rr third ch0 fall", got[2], mk(0, 0, c + 5));
    do_reset(); ev_ready = 1; step(4);
    c = tick; disc_in = 4'b1111;
    wait_got(4); step(4);
    for (int i = 0; i < 4; i++) chk("R6 simultaneous order", got[i], mk(i, 1, c + 2));
  endtask

  task automatic t_stall();
    int c;
    logic [RW-1:0] held;
    do_reset(); step(4);
    c = tick; disc_in[3] = 1;
    for (int i = 0; i < 20 && !ev_valid; i++) step(1);
    held = ev_data;
    chk("R7 offered record", held, mk(3, 1, c + 2));
    disc_in[0] = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #1;
      chk("R7 valid held", ev_valid, 1);
      chk("R7 data held", ev_data, held);
    end
    ev_ready = 1;
    wait_got(2); step(3);
    chk("R7 first after stall", got[0], held);
    chk("R7 second after stall ch0", got[1][RW-1 -: 3], {2'd0, 1'b1});
  endtask

  task automatic t_overflow();
    int c;
    do_reset(); step(4);
    c = tick;
    for (int i = 0; i < 6; i++) begin
      disc_in[1] = ~disc_in[1];
      step(2);
    end
    step(6); #1;
    chk("R8 ovf set on drop", ovf_flag, 1);
    ev_ready = 1;
    wait_got(4); step(10);
    chk("R5 stored count", ngot, 4);
    for (int i = 0; i < 4; i++)
      chk("R5 stored order", got[i], mk(1, (i % 2) == 0, c + 2 + 2 * i));
    #1;
    chk("R8 ovf sticky", ovf_flag, 1);
    @(negedge clk); ovf_clr = 1;
    @(negedge clk); ovf_clr = 0; #1;
    chk("R8 ovf cleared", ovf_flag, 0);
  endtask

  task automatic t_wrap();
    int lim;
    do_reset(); ev_ready = 1;
    lim = (1 << TSW) - 3;
    while (tick < lim) step(1);
    disc_in[0] = 1;
    step(3);
    disc_in[0] = 0;
    wait_got(2); step(3);
    chk("R9 stamp before wrap", got[0], mk(0, 1, (1 << TSW) - 1));
    chk("R9 stamp after wrap", got[1], mk(0, 0, 2));
    chk("R9 width across wrap", TSW'(got[1][TSW-1:0] - got[0][TSW-1:0]), 3);
  endtask

  initial begin
    t_reset();
    t_single_pulse();
    t_round_robin();
    t_stall();
    t_overflow();
    t_wrap();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule